// File: doc/BRIEF.md
# RAM Window Access Controller

This block is the slave-side gatekeeper for a small on-chip RAM array on a 32-bit processor bus. Each bus request is a one-cycle strobe carrying an address, a read/write flag, a transfer size, a privilege attribute and write data. The block decides whether the request falls in the RAM window or in its own small register block. It then either drives the RAM-side port and acknowledges, answers a register access, raises a bus error, or leaves the request unclaimed so that other logic on the bus may decode it.

The RAM window is placed by a base register that holds the upper half of the window's start address. That register can be written only once after reset, which stops stray software from moving the array. A protection bit can limit the array to privileged masters. A stop bit turns off the module clock enable. While it is set, only the stop bit itself can be reached. A write to the test register position is always refused with a bus error.

Top module: `ram_window_ctl`

## Requirements
- R1: After reset the base register is 0x0000 and unlocked, protection and stop are 0, `mod_clk_en` is 1, and `bus_ack`, `bus_berr` and `ram_en` are low.
- R2: A request is a RAM access when address bits 31:16 equal the base register and address bits 15:0 are below the window size (4 << RAM_AW bytes, 1 KiB by default). Such an access drives `ram_en` in the request cycle and is acknowledged in the following cycle.
- R3: The first write to the base register (register index 1, data bits 15:0) loads it and locks it. Every later write leaves it unchanged until reset.
- R4: Configuration bit 7 is the protection bit. When it is 1, a request with `bus_priv` low to the RAM window gets neither an acknowledge nor a bus error, keeps `ram_en` low and leaves the array unchanged. Privileged requests still complete.
- R5: A write to register index 2 (the test position) produces `bus_berr` in the next cycle with no acknowledge. A read there is acknowledged with data zero.
- R6: Configuration bit 0 is the stop bit. `mod_clk_en` equals its inverse.
- R7: While stop is 1, only the configuration register responds. Its reads return just the stop bit, and its writes change only the stop bit. All other register and RAM requests get no response and no RAM activity.
- R8: The register block spans four 32-bit words from REG_BASE (default 0x0030_0000): index 0 configuration, 1 base, 2 test, 3 spare (reads zero, writes ignored). A register access is acknowledged in the cycle after the request and takes priority over the RAM window.
- R9: Configuration bits other than 0 and 7 read as zero and ignore writes.
- R10: Byte lanes are little-endian by address bits 1:0. Size 0 enables one lane, size 1 enables the halfword pair selected by bit 1, and sizes 2 and 3 enable all four. Write data passes to the RAM in place.
- R11: `bus_rdata` is zero except in a cycle that acknowledges a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | One-cycle request strobe |
| bus_addr | input | 32 | Byte address |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_priv | input | 1 | 1 for a privileged master |
| bus_wdata | input | 32 | Write data in lane position |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| bus_ack | output | 1 | Access completed |
| bus_berr | output | 1 | Access refused with error |
| mod_clk_en | output | 1 | Module clock enable, low while stopped |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write |
| ram_addr | output | RAM_AW | RAM word address |
| ram_be | output | 4 | RAM byte lane enables |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after `ram_en` |

## Verification
The assertions assume that requests are one-cycle strobes with stable attributes in that cycle. They also assume the RAM returns read data exactly one cycle after `ram_en`, since the read path muxes that data straight through. The bench holds to both: it drives each request for a single cycle on a falling edge and leaves an idle cycle after it, and its RAM model is a synchronous array with one cycle of read latency. The random phase sizes and aligns addresses to the transfer size. It sets the stop bit in only a quarter of configuration writes, so the stopped and running states both get long stretches.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

    localparam int unsigned DATA_W       = 32;
    localparam int unsigned ADDR_W       = 32;
    localparam int unsigned BASE_W       = 16;
    localparam int unsigned LANES        = DATA_W / 8;
    localparam int unsigned REG_IDX_W    = 2;
    localparam int unsigned CFG_STOP_BIT = 0;
    localparam int unsigned CFG_PROT_BIT = 7;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_CFG   = 2'd0,
        IDX_BASE  = 2'd1,
        IDX_TEST  = 2'd2,
        IDX_SPARE = 2'd3
    } reg_idx_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_RAM,
        TGT_CFG,
        TGT_BASE,
        TGT_TEST,
        TGT_SPARE
    } tgt_e;

    typedef struct packed {
        logic              ack;
        logic              berr;
        logic              from_ram;
        logic [DATA_W-1:0] rdata;
    } resp_t;

    // Lane enables for a transfer of the given size at the given byte offset.
    function automatic logic [LANES-1:0] lane_mask(logic [1:0] size, logic [1:0] off);
        logic [LANES-1:0] m;
        case (size)
            2'd0:    m = 4'b0001 << off;
            2'd1:    m = off[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

    // Visible image of the configuration register.
    function automatic logic [BASE_W-1:0] cfg_image(logic stop, logic prot);
        logic [BASE_W-1:0] v;
        v = '0;
        v[CFG_STOP_BIT] = stop;
        if (!stop) v[CFG_PROT_BIT] = prot;
        return v;
    endfunction

endpackage

// File: rtl/rwc_decode.sv
module rwc_decode
    import rwc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_BASE = 32'h0030_0000,
    parameter int unsigned       RAM_AW   = 8
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              priv,
    input  logic [BASE_W-1:0] base,
    input  logic              prot,
    input  logic              stop,
    output tgt_e              tgt
);
    localparam int unsigned      RAM_BYTES = 4 << RAM_AW;
    localparam logic [BASE_W:0]  RAM_LIMIT = (BASE_W+1)'(RAM_BYTES);
    localparam int unsigned      REG_LSB   = REG_IDX_W + 2;

    logic     reg_hit;
    logic     win_hit;
    logic     access_ok;
    reg_idx_e idx;

    assign reg_hit   = addr[ADDR_W-1:REG_LSB] == REG_BASE[ADDR_W-1:REG_LSB];
    assign win_hit   = (addr[ADDR_W-1:BASE_W] == base) &&
                       ({1'b0, addr[BASE_W-1:0]} < RAM_LIMIT);
    assign access_ok = !prot || priv;
    assign idx       = reg_idx_e'(addr[REG_LSB-1:2]);

    always_comb begin
        tgt = TGT_NONE;
        if (valid) begin
            if (reg_hit) begin
                if (!stop || idx == IDX_CFG) begin
                    case (idx)
                        IDX_CFG:  tgt = TGT_CFG;
                        IDX_BASE: tgt = TGT_BASE;
                        IDX_TEST: tgt = TGT_TEST;
                        default:  tgt = TGT_SPARE;
                    endcase
                end
            end else if (win_hit && !stop && access_ok) begin
                tgt = TGT_RAM;
            end
        end
    end

endmodule

// File: rtl/rwc_cfg.sv
module rwc_cfg
    import rwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tgt_e              tgt,
    input  logic              write,
    input  logic [BASE_W-1:0] wdata,
    output logic              stop,
    output logic              prot,
    output logic [BASE_W-1:0] base,
    output logic              locked,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stop   <= 1'b0;
            prot   <= 1'b0;
            base   <= '0;
            locked <= 1'b0;
        end else if (write) begin
            case (tgt)
                TGT_CFG: begin
                    stop <= wdata[CFG_STOP_BIT];
                    if (!stop) prot <= wdata[CFG_PROT_BIT];
                end
                TGT_BASE: begin
                    if (!locked) begin
                        base   <= wdata;
                        locked <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (tgt)
            TGT_CFG:  rdata = {{(DATA_W-BASE_W){1'b0}}, cfg_image(stop, prot)};
            TGT_BASE: rdata = {{(DATA_W-BASE_W){1'b0}}, base};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/rwc_ramport.sv
module rwc_ramport
    import rwc_pkg::*;
#(
    parameter int unsigned RAM_AW = 8
) (
    input  tgt_e              tgt,
    input  logic              write,
    input  logic [1:0]        size,
    input  logic [RAM_AW+1:0] addr_lo,
    input  logic [DATA_W-1:0] wdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [LANES-1:0]  ram_be,
    output logic [DATA_W-1:0] ram_wdata
);
    assign ram_en    = (tgt == TGT_RAM);
    assign ram_we    = ram_en && write;
    assign ram_addr  = addr_lo[RAM_AW+1:2];
    assign ram_be    = ram_en ? lane_mask(size, addr_lo[1:0]) : '0;
    assign ram_wdata = wdata;

endmodule

// File: rtl/ram_window_ctl.sv
module ram_window_ctl
    import rwc_pkg::*;
#(
    parameter logic [31:0] REG_BASE = 32'h0030_0000,
    parameter int unsigned RAM_AW   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic [31:0]       bus_addr,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic              bus_priv,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ack,
    output logic              bus_berr,
    output logic              mod_clk_en,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [3:0]        ram_be,
    output logic [31:0]       ram_wdata,
    input  logic [31:0]       ram_rdata
);
    tgt_e              tgt;
    logic              cfg_stop;
    logic              cfg_prot;
    logic [BASE_W-1:0] base_q;
    logic              base_locked;
    logic [DATA_W-1:0] reg_rdata;
    resp_t             resp_q;
    logic              refuse;

    rwc_decode #(
        .REG_BASE (REG_BASE),
        .RAM_AW   (RAM_AW)
    ) u_decode (
        .valid (bus_valid),
        .addr  (bus_addr),
        .priv  (bus_priv),
        .base  (base_q),
        .prot  (cfg_prot),
        .stop  (cfg_stop),
        .tgt   (tgt)
    );

    rwc_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .tgt    (tgt),
        .write  (bus_write),
        .wdata  (bus_wdata[BASE_W-1:0]),
        .stop   (cfg_stop),
        .prot   (cfg_prot),
        .base   (base_q),
        .locked (base_locked),
        .rdata  (reg_rdata)
    );

    rwc_ramport #(
        .RAM_AW (RAM_AW)
    ) u_ramport (
        .tgt       (tgt),
        .write     (bus_write),
        .size      (bus_size),
        .addr_lo   (bus_addr[RAM_AW+1:0]),
        .wdata     (bus_wdata),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_be    (ram_be),
        .ram_wdata (ram_wdata)
    );

    assign refuse = (tgt == TGT_TEST) && bus_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.ack      <= (tgt != TGT_NONE) && !refuse;
            resp_q.berr     <= refuse;
            resp_q.from_ram <= (tgt == TGT_RAM) && !bus_write;
            resp_q.rdata    <= (tgt != TGT_RAM && !bus_write) ? reg_rdata : '0;
        end
    end

    assign bus_ack    = resp_q.ack;
    assign bus_berr   = resp_q.berr;
    assign bus_rdata  = resp_q.from_ram ? ram_rdata : resp_q.rdata;
    assign mod_clk_en = !cfg_stop;

endmodule

// File: rtl/rwc_checker.sv
module rwc_checker #(
    parameter logic [31:0] REG_BASE = 32'h0030_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_valid,
    input logic [31:0] bus_addr,
    input logic        bus_write,
    input logic        bus_priv,
    input logic [31:0] bus_rdata,
    input logic        bus_ack,
    input logic        bus_berr,
    input logic        mod_clk_en,
    input logic        ram_en,
    input logic [3:0]  ram_be,
    input logic        prot,
    input logic        locked,
    input logic [15:0] base
);
    localparam logic [29:0] TEST_WORD = 30'((REG_BASE + 32'd8) >> 2);

    // R5
    a_r5_test_write_berr: assert property (@(posedge clk) disable iff (rst)
        bus_valid && bus_write && bus_addr[31:2] == TEST_WORD && mod_clk_en
        |=> bus_berr && !bus_ack);

    // R5
    a_r5_berr_needs_write: assert property (@(posedge clk) disable iff (rst)
        bus_berr |-> $past(bus_valid && bus_write));

    // R8
    a_r8_ack_berr_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(bus_ack && bus_berr));

    // R4
    a_r4_user_kept_out: assert property (@(posedge clk) disable iff (rst)
        bus_valid && !bus_priv && prot |-> !ram_en);

    // R3
    a_r3_base_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked && $stable(base));

    // R7
    a_r7_stopped_ram_idle: assert property (@(posedge clk) disable iff (rst)
        !mod_clk_en |-> !ram_en);

    // R11
    a_r11_quiet_data: assert property (@(posedge clk) disable iff (rst)
        !bus_ack |-> bus_rdata == 32'h0);

    // R2
    a_r2_ram_needs_request: assert property (@(posedge clk) disable iff (rst)
        ram_en |-> bus_valid);

    // R10
    a_r10_lanes_present: assert property (@(posedge clk) disable iff (rst)
        ram_en |-> ram_be != 4'b0000);

endmodule

bind ram_window_ctl rwc_checker #(.REG_BASE(REG_BASE)) u_rwc_checker (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_addr   (bus_addr),
    .bus_write  (bus_write),
    .bus_priv   (bus_priv),
    .bus_rdata  (bus_rdata),
    .bus_ack    (bus_ack),
    .bus_berr   (bus_berr),
    .mod_clk_en (mod_clk_en),
    .ram_en     (ram_en),
    .ram_be     (ram_be),
    .prot       (cfg_prot),
    .locked     (base_locked),
    .base       (base_q)
);

// File: tb/ram_window_ctl_bench.sv
module ram_window_ctl_bench;

    localparam logic [31:0] REG_BASE = 32'h0030_0000;
    localparam int unsigned RAM_AW   = 8;
    localparam int unsigned WORDS    = 1 << RAM_AW;
    localparam int unsigned HALF_PER = 10; // 20 ns period, 50 MHz

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic [31:0]       bus_addr = '0;
    logic              bus_write = 1'b0;
    logic [1:0]        bus_size = '0;
    logic              bus_priv = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_ack;
    logic              bus_berr;
    logic              mod_clk_en;
    logic              ram_en;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [3:0]        ram_be;
    logic [31:0]       ram_wdata;
    logic [31:0]       ram_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench reference state
    logic [15:0] m_base = '0;
    logic        m_lock = 1'b0;
    logic        m_prot = 1'b0;
    logic        m_stop = 1'b0;
    logic [31:0] shadow [WORDS];
    logic [31:0] mem    [WORDS];

    always #HALF_PER clk = ~clk;

    ram_window_ctl #(.REG_BASE(REG_BASE), .RAM_AW(RAM_AW)) u_ram_window_ctl (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_size(bus_size), .bus_priv(bus_priv),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_berr(bus_berr), .mod_clk_en(mod_clk_en), .ram_en(ram_en),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // synchronous RAM model, one cycle read latency
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin
                for (int b = 0; b < 4; b++)
                    if (ram_be[b]) mem[ram_addr][b*8 +: 8] <= ram_wdata[b*8 +: 8];
            end else begin
                ram_rdata <= mem[ram_addr];
            end
        end
    end

    function automatic logic [3:0] exp_lanes(logic [1:0] sz, logic [1:0] off);
        if (sz == 2'd0) return 4'b0001 << off;
        if (sz == 2'd1) return off[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compute the expected response from R2..R11 and update the reference state.
    task automatic model(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                         input logic pv, input logic [31:0] wd,
                         output logic e_ack, output logic e_berr,
                         output logic [31:0] e_data, output logic e_ram);
        logic       reg_hit;
        logic [1:0] idx;
        logic [3:0] be;
        int         w;
        reg_hit = a[31:4] == REG_BASE[31:4];
        idx     = a[3:2];
        e_ack = 1'b0; e_berr = 1'b0; e_data = '0; e_ram = 1'b0;
        if (reg_hit) begin
            if (m_stop && idx != 2'd0) begin
                e_ack = 1'b0;
            end else if (idx == 2'd2 && wr) begin
                e_berr = 1'b1;
            end else begin
                e_ack = 1'b1;
                if (!wr) begin
                    if (idx == 2'd0) e_data = m_stop ? 32'h1 : {24'h0, m_prot, 7'h0};
                    else if (idx == 2'd1) e_data = {16'h0, m_base};
                end else if (idx == 2'd0) begin
                    if (!m_stop) m_prot = wd[7];
                    m_stop = wd[0];
                end else if (idx == 2'd1 && !m_lock) begin
                    m_base = wd[15:0];
                    m_lock = 1'b1;
                end
            end
        end else if (a[31:16] == m_base && a[15:0] < 16'd1024 && !m_stop && (!m_prot || pv)) begin
            e_ack = 1'b1;
            e_ram = 1'b1;
            w = int'(a[9:2]);
            if (wr) begin
                be = exp_lanes(sz, a[1:0]);
                for (int b = 0; b < 4; b++)
                    if (be[b]) shadow[w][b*8 +: 8] = wd[b*8 +: 8];
            end else begin
                e_data = shadow[w];
            end
        end
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic wr,
                          input logic [1:0] sz, input logic pv, input logic [31:0] wd);
        logic        e_ack, e_berr, e_ram;
        logic [31:0] e_data;
        model(a, wr, sz, pv, wd, e_ack, e_berr, e_data, e_ram);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_write = wr;
        bus_size = sz; bus_priv = pv; bus_wdata = wd;
        #1;
        chk(req, "ram_en", {31'h0, ram_en}, {31'h0, e_ram});
        if (e_ram && !wr) chk("R10", "ram_be", {28'h0, ram_be}, {28'h0, exp_lanes(sz, a[1:0])});
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        chk(req, "ack", {31'h0, bus_ack}, {31'h0, e_ack});
        chk(req, "berr", {31'h0, bus_berr}, {31'h0, e_berr});
        chk(e_ack && !wr ? req : "R11", "rdata", bus_rdata, e_data);
        chk("R6", "mod_clk_en", {31'h0, mod_clk_en}, {31'h0, !m_stop});
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i]    = '0;
            shadow[i] = '0;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, wd;
        logic [1:0]  sz;
        int          kind;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "ack", {31'h0, bus_ack}, 32'h0);
        chk("R1", "berr", {31'h0, bus_berr}, 32'h0);
        chk("R1", "mod_clk_en", {31'h0, mod_clk_en}, 32'h1);
        chk("R1", "ram_en", {31'h0, ram_en}, 32'h0);
        access("R1", REG_BASE + 32'h0, 1'b0, 2'd2, 1'b1, '0);
        access("R1", REG_BASE + 32'h4, 1'b0, 2'd2, 1'b1, '0);
        // R2 window at reset base 0
        access("R2", 32'h0000_0010, 1'b1, 2'd2, 1'b1, 32'hCAFE_0001);
        access("R2", 32'h0000_0010, 1'b0, 2'd2, 1'b1, '0);
        // R3 base write once
        access("R3", REG_BASE + 32'h4, 1'b1, 2'd2, 1'b1, 32'h0000_1234);
        access("R3", REG_BASE + 32'h4, 1'b0, 2'd2, 1'b1, '0);
        access("R3", REG_BASE + 32'h4, 1'b1, 2'd2, 1'b1, 32'h0000_BEEF);
        access("R3", REG_BASE + 32'h4, 1'b0, 2'd2, 1'b1, '0);
        // R2 window edges after the move
        access("R2", 32'h1234_03FC, 1'b1, 2'd2, 1'b1, 32'h1122_3344);
        access("R2", 32'h1234_03FC, 1'b0, 2'd2, 1'b0, '0);
        access("R2", 32'h1234_0400, 1'b0, 2'd2, 1'b1, '0);
        access("R2", 32'h1235_0000, 1'b0, 2'd2, 1'b1, '0);
        access("R2", 32'h0000_0010, 1'b0, 2'd2, 1'b1, '0);
        // R10 byte and halfword lanes
        access("R10", 32'h1234_0020, 1'b1, 2'd2, 1'b1, 32'h0000_0000);
        access("R10", 32'h1234_0021, 1'b1, 2'd0, 1'b1, 32'hFFFF_AAFF);
        access("R10", 32'h1234_0022, 1'b1, 2'd1, 1'b1, 32'h5566_FFFF);
        access("R10", 32'h1234_0020, 1'b0, 2'd2, 1'b1, '0);
        // R9 reserved bits, R4 protection
        access("R9", REG_BASE, 1'b1, 2'd2, 1'b1, 32'hFFFF_FFFE);
        access("R9", REG_BASE, 1'b0, 2'd2, 1'b1, '0);
        access("R4", 32'h1234_0020, 1'b0, 2'd2, 1'b0, '0);
        access("R4", 32'h1234_0020, 1'b1, 2'd2, 1'b0, 32'hDEAD_DEAD);
        access("R4", 32'h1234_0020, 1'b0, 2'd2, 1'b1, '0);
        access("R4", REG_BASE, 1'b1, 2'd2, 1'b1, 32'h0);
        access("R4", 32'h1234_0020, 1'b0, 2'd2, 1'b0, '0);
        // R5 test position, R8 spare
        access("R5", REG_BASE + 32'h8, 1'b1, 2'd2, 1'b1, 32'h1);
        access("R5", REG_BASE + 32'h8, 1'b0, 2'd2, 1'b1, '0);
        access("R8", REG_BASE + 32'hC, 1'b1, 2'd2, 1'b1, 32'hFFFF_FFFF);
        access("R8", REG_BASE + 32'hC, 1'b0, 2'd2, 1'b1, '0);
        // R6, R7 stop
        access("R6", REG_BASE, 1'b1, 2'd2, 1'b1, 32'h1);
        access("R7", REG_BASE, 1'b0, 2'd2, 1'b1, '0);
        access("R7", REG_BASE + 32'h4, 1'b0, 2'd2, 1'b1, '0);
        access("R7", REG_BASE + 32'h8, 1'b1, 2'd2, 1'b1, '0);
        access("R7", 32'h1234_0020, 1'b0, 2'd2, 1'b1, '0);
        access("R7", REG_BASE, 1'b1, 2'd2, 1'b1, 32'h80);
        access("R7", REG_BASE, 1'b0, 2'd2, 1'b1, '0);
        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            kind = int'($urandom % 8);
            sz   = 2'($urandom % 3);
            wd   = $urandom;
            if (kind < 5) begin
                a = {m_base, 6'h0, 10'($urandom % 1024)};
            end else if (kind == 5) begin
                a = REG_BASE;
                wd[0] = ($urandom % 4) == 0;
            end else if (kind == 6) begin
                a = REG_BASE + {28'h0, 2'($urandom % 4), 2'b00};
            end else begin
                a = $urandom;
            end
            if (sz == 2'd1) a[0] = 1'b0;
            if (sz == 2'd2) a[1:0] = 2'b00;
            access("R2", a, 1'($urandom % 2), sz, 1'($urandom % 2), wd);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule